// File: doc/BRIEF.md
# Reset Pin Controller with Watchdog Drive-Out

This block is the reset controller for an 8-bit microcontroller core whose reset pin works in both directions. From the outside, the pin is an active-high reset request. The block samples the pin on the oscillator clock and raises the core's internal reset only after the pin has stayed high for two machine cycles. One machine cycle is twelve oscillator periods.

From the inside, a one-cycle timeout strobe from the watchdog raises the internal reset for a fixed interval of 98 oscillator periods. In the same interval the block enables the pin's output driver, so that other devices on the board also see the reset. One bit in an auxiliary control register turns the pin drive off. The internal reset is still applied in that case.

The drive-out runs in a small state machine with three states:
- `ST_IDLE`: no drive-out is in progress.
- `ST_DRIVE`: the interval is running with the pin driven.
- `ST_SILENT`: the interval is running with the pin left undriven.

The transitions are:
- *timeout-drive* (`ST_IDLE` to `ST_DRIVE`, on a strobe while the disable bit is clear).
- *timeout-silent* (`ST_IDLE` to `ST_SILENT`, on a strobe while the disable bit is set).
- *interval-end* (either running state back to `ST_IDLE`, after the 98th period).

Top module: `rstpin_ctrl`

## Requirements
- R1: After `por_n` is released with the pin low, `core_rst` and `pin_oe` are both 0.
- R2: `core_rst` rises only after 24 consecutive synchronized high samples of `pin_in`. Counting the two-flop synchronizer, it is high from the 26th rising edge after the pin goes high. A high run of 23 samples never raises it.
- R3: A single low sample before the count completes restarts the count from zero.
- R4: Once qualified, the external reset holds `core_rst` high for as long as the pin stays high. `core_rst` falls on the third edge after the pin goes low.
- R5: A `wdt_expire` strobe taken in `ST_IDLE` with the disable bit clear raises `pin_oe` and `core_rst` from the next edge, for exactly 98 clock periods.
- R6: Writing 1 to bit 3 of the register at address 0x8E sets the disable bit. A later strobe then raises `core_rst` for 98 periods while `pin_oe` stays 0.
- R7: Writes to any other address leave the disable bit unchanged.
- R8: The disable bit is 0 after `por_n`. It is also cleared whenever `core_rst` is high, so a second timeout after a silent interval drives the pin again.
- R9: A strobe that arrives while an interval is running neither restarts it nor lengthens it.
- R10: The block's own drive of the pin, read back through `pin_in`, is not counted as an external reset. `core_rst` falls exactly when the 98-period interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Level read back from the reset pin |
| pin_oe | output | 1 | Enables the driver that pulls the reset pin high |
| wdt_expire | input | 1 | One-cycle watchdog timeout strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| core_rst | output | 1 | Internal reset to the core, active high |

## Verification
An error in the qualification counter shows up on `core_rst` as an edge that is off by a cycle. The bench checks the exact 26th edge, the 23-sample miss and the restart after a one-sample gap.

A wrong state or a wrong interval count shows up as a `pin_oe` or `core_rst` pulse that is not exactly 98 periods long. It can also show up as a pin driven when it should not be, which is visible from the first cycle after the strobe.

A disable bit that is stuck, or that is not cleared by reset, is only visible at the next timeout. For that reason every register write is followed by a strobe whose pin behaviour is compared cycle by cycle.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_SILENT = 2'd2
    } drv_state_e;
endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rp_qual.sv
module rp_qual #(
    parameter int QUAL_LEN = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic mask,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(QUAL_LEN);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_cnt <= '0;
        else if (mask || !level)   run_cnt <= '0;
        else if (run_cnt != FULL)  run_cnt <= run_cnt + CW'(1);
    end

    assign qualified = (run_cnt == FULL);

    AST_QUAL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(level)); // R2
    AST_QUAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !level |=> !qualified); // R4
endmodule

// File: rtl/rp_auxreg.sv
module rp_auxreg #(
    parameter int              AW       = 8,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   REG_ADDR = 8'h8E,
    parameter int              OFF_BIT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          drive_off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       drive_off <= 1'b0;
        else if (clr)                     drive_off <= 1'b0;
        else if (we && addr == REG_ADDR)  drive_off <= wdata[OFF_BIT];
    end

    AST_CLEAR_ON_RST: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !drive_off); // R8
    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(we && addr == REG_ADDR)) |=> $stable(drive_off)); // R7
endmodule

// File: rtl/rp_drive_fsm.sv
module rp_drive_fsm
    import rstpin_pkg::*;
#(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic drive_off,
    output logic busy,
    output logic pin_oe
);
    localparam int TW = $clog2(PULSE_LEN);
    localparam logic [TW-1:0] LAST = TW'(PULSE_LEN - 1);

    drv_state_e    state, state_nx;
    logic [TW-1:0] tcnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (strobe) state_nx = drive_off ? ST_SILENT : ST_DRIVE;
            ST_DRIVE,
            ST_SILENT: if (tcnt == LAST) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) tcnt <= '0;
            else                  tcnt <= tcnt + TW'(1);
        end
    end

    always_comb begin
        busy   = (state != ST_IDLE);
        pin_oe = (state == ST_DRIVE);
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tcnt <= LAST); // R5
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && strobe && tcnt != LAST) |=> (busy && tcnt == $past(tcnt) + TW'(1))); // R9
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl #(
    parameter int          OSC_PER_MC = 12,
    parameter int          MC_QUAL    = 2,
    parameter int          PULSE_LEN  = 98,
    parameter int          SYNC_STG   = 2,
    parameter logic [7:0]  AUX_ADDR   = 8'h8E,
    parameter int          OFF_BIT    = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_in,
    output logic       pin_oe,
    input  logic       wdt_expire,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic       core_rst
);
    localparam int QUAL_LEN = OSC_PER_MC * MC_QUAL;

    logic pin_s, ext_ok, busy, drive_off;

    rp_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(por_n), .d(pin_in), .q(pin_s)
    );

    rp_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
        .clk(clk), .rst_n(por_n), .level(pin_s), .mask(busy), .qualified(ext_ok)
    );

    rp_auxreg #(.AW(8), .DW(8), .REG_ADDR(AUX_ADDR), .OFF_BIT(OFF_BIT)) u_aux (
        .clk(clk), .rst_n(por_n), .clr(core_rst), .we(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .drive_off(drive_off)
    );

    rp_drive_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk(clk), .rst_n(por_n), .strobe(wdt_expire), .drive_off(drive_off),
        .busy(busy), .pin_oe(pin_oe)
    );

    assign core_rst = busy | ext_ok;

    AST_OE_HOLDS_RST: assert property (@(posedge clk) disable iff (!por_n)
        pin_oe |-> core_rst); // R5
    AST_SILENT_TIMEOUT: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_expire && !busy && drive_off) |=> (core_rst && !pin_oe)); // R6
    AST_LOUD_TIMEOUT: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_expire && !busy && !drive_off) |=> (core_rst && pin_oe)); // R5
endmodule

// File: tb/test_rstpin_ctrl.sv
module test_rstpin_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic rst;
        logic oe;
        int   req;
    } exp_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_drv = 1'b0;
    logic       wdt_expire = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       pin_oe, core_rst, pin_in;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // pad model: external source OR the block's own driver
    assign pin_in = ext_drv | pin_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstpin_ctrl i_rstpin_ctrl (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .pin_oe(pin_oe),
        .wdt_expire(wdt_expire), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .core_rst(core_rst)
    );

    // driver: sets inputs at a falling edge, queues the outputs expected after the next rise
    task automatic tick(input logic ext, input logic wdt, input logic we,
                        input logic [7:0] a, input logic [7:0] d,
                        input logic e_rst, input logic e_oe, input int req);
        exp_t it;
        @(negedge clk);
        ext_drv = ext; wdt_expire = wdt; reg_we = we; reg_addr = a; reg_wdata = d;
        it.rst = e_rst; it.oe = e_oe; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic timeout_run(input logic expect_oe, input int req);
        for (int i = 0; i < 102; i++)
            tick(1'b0, i == 0, 1'b0, 8'h00, 8'h00, i < 98, expect_oe && i < 98, req);
    endtask

    // monitor: compares a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (core_rst !== it.rst || pin_oe !== it.oe) begin
                n_fail++;
                $display("FAIL R%0d: core_rst=%b pin_oe=%b expected core_rst=%b pin_oe=%b at %0t",
                         it.req, core_rst, pin_oe, it.rst, it.oe, $time);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R1: quiet after reset
        for (int i = 0; i < 5; i++) tick(0, 0, 0, 8'h00, 8'h00, 0, 0, 1);
        // R2: 23 high samples are not enough
        for (int i = 0; i < 23; i++) tick(1, 0, 0, 8'h00, 8'h00, 0, 0, 2);
        for (int i = 0; i < 6; i++)  tick(0, 0, 0, 8'h00, 8'h00, 0, 0, 2);
        // R3: 20 high, one low, then a fresh qualification
        for (int i = 0; i < 20; i++) tick(1, 0, 0, 8'h00, 8'h00, 0, 0, 3);
        tick(0, 0, 0, 8'h00, 8'h00, 0, 0, 3);
        // R2 / R4: rises at item 25, held while the pin stays high
        for (int i = 0; i < 60; i++) tick(1, 0, 0, 8'h00, 8'h00, i >= 25, 0, (i < 30) ? 2 : 4);
        // R4: falls on the third edge after release
        for (int i = 0; i < 6; i++)  tick(0, 0, 0, 8'h00, 8'h00, i < 2, 0, 4);
        // R5 / R10: pin driven for exactly 98 periods, own echo ignored
        timeout_run(1'b1, 5);
        // R6: set the disable bit (bit 3 at 0x8E), then a silent interval
        tick(0, 0, 1, 8'h8E, 8'h08, 0, 0, 6);
        timeout_run(1'b0, 6);
        // R8: the bit was cleared by the internal reset, so the pin drives again
        timeout_run(1'b1, 8);
        // R7: a write to another address leaves the bit clear
        tick(0, 0, 1, 8'h8F, 8'hFF, 0, 0, 7);
        timeout_run(1'b1, 7);
        // R7: clearing bit 3 at the right address keeps the drive
        tick(0, 0, 1, 8'h8E, 8'hF7, 0, 0, 7);
        timeout_run(1'b1, 7);
        // R9: a second strobe mid-interval does not extend it
        for (int i = 0; i < 102; i++)
            tick(0, i == 0 || i == 50, 0, 8'h00, 8'h00, i < 98, i < 98, 9);
        // R10: with the pad read-back, no stray reset after the interval
        for (int i = 0; i < 30; i++) tick(0, 0, 0, 8'h00, 8'h00, 0, 0, 10);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule